// File: doc/BRIEF.md
# End-Of-Interrupt Deactivation Unit

This block serves the completion side of a virtual interrupt CPU interface. It accepts one request per cycle. A request is either an end-of-interrupt (EOI) write or an explicit deactivate write, and carries an interrupt ID and, for EOI, the interrupt group. Every EOI raises a priority-drop request toward the active-priority tracker in the same cycle. The tracker returns the priority level it dropped. The unit then decides whether the request should also retire the interrupt. That depends on the completion mode and on whether the ID is a message-based (LPI) interrupt.

When deactivation is wanted, the unit scans its list entries for the first used, active entry with the same virtual ID. It clears that entry's active bit. If the entry is backed by a physical interrupt, the unit emits a one-cycle physical-deactivate pulse carrying the physical ID. If no entry matches, a 5-bit miss counter advances. An EOI only retires an entry whose group and preemption level agree with the EOI group and the dropped priority.

The list entries are written by the acknowledge path through a write port. A read port exposes each entry's ID and active bit.

Top module: `eoi_deact_unit`

## Requirements
- R1: `drop_req` is high in exactly the cycles that carry an EOI request (`req_valid`=1, `req_kind`=0), for any ID, group or mode; a deactivate request (`req_kind`=1) never raises it.
- R2: A request whose ID is 8192 or above (LPI) never clears an entry, never pulses `pdeact_valid` and never changes `eoi_count`.
- R3: With `eoi_mode`=1, an EOI only drops priority: no entry changes, no pulse, no count change.
- R4: With `eoi_mode`=0, a deactivate request has no effect at all.
- R5: The search considers only entries with index below `lr_used`, requires an equal ID and the active bit set, and picks the lowest such index.
- R6: When deactivation is wanted and no entry matches, `eoi_count` increases by one, wrapping from 31 to 0, in the cycle after the request; it never changes by any other amount.
- R7: On an EOI hit, the entry is retired only if its group equals `req_grp` and its preemption level equals `drop_prio`. Otherwise nothing changes and the count does not move.
- R8: Retiring an entry clears its active bit. If the entry's hardware bit is set, `pdeact_valid` is high for the one cycle after the request with `pdeact_id` equal to the entry's physical ID. Otherwise no pulse appears.
- R9: Preemption level is the 8-bit priority with its low bits cleared: `bpr_g0`+1 bits for group 0, `bpr_g1` bits for group 1.
- R10: After reset, `eoi_count` is 0, `pdeact_valid` is 0 and every entry reads inactive.
- R11: An entry write stores ID, physical ID, priority, group, active and hardware bits at `lr_wr_idx`, visible on the read port from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lr_wr_en | input | 1 | Entry write strobe from the acknowledge path |
| lr_wr_idx | input | IDX_W | Entry index to write |
| lr_wr_vid | input | VID_W | Virtual interrupt ID |
| lr_wr_pid | input | PID_W | Physical interrupt ID |
| lr_wr_prio | input | 8 | Entry priority |
| lr_wr_grp | input | 1 | Entry group |
| lr_wr_act | input | 1 | Entry active bit |
| lr_wr_hw | input | 1 | Entry is hardware-backed |
| lr_used | input | USE_W | Number of entries in use |
| eoi_mode | input | 1 | 0: EOI drops and retires; 1: split drop and deactivate |
| bpr_g0 | input | 3 | Group 0 binary point |
| bpr_g1 | input | 3 | Group 1 binary point |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 1 | 0: EOI, 1: deactivate |
| req_id | input | VID_W | Interrupt ID of the request |
| req_grp | input | 1 | Group of an EOI request |
| drop_req | output | 1 | Priority-drop request to the tracker |
| drop_prio | input | 8 | Priority level dropped by the tracker |
| pdeact_valid | output | 1 | Physical-deactivate pulse |
| pdeact_id | output | PID_W | Physical ID to deactivate |
| eoi_count | output | CNT_W | Miss counter |
| lr_rd_idx | input | IDX_W | Entry index to read |
| lr_rd_vid | output | VID_W | ID of the read entry |
| lr_rd_act | output | 1 | Active bit of the read entry |

## Verification
The assertions watch every cycle for the following:
- the miss counter only ever steps by one;
- a physical-deactivate pulse only follows a non-LPI request and never coincides with a counter step;
- LPI IDs, EOIs in split mode and deactivates in combined mode leave both the pulse and the counter untouched.

Some behaviours are visible only through the bench's scenarios:
- which entry the search selects when IDs repeat or lie beyond the used count;
- the group and preemption-level check, including both binary-point shifts;
- the wrap of the counter;
- the active bits seen through the read port.

// File: rtl/eoi_pkg.sv
package eoi_pkg;

    typedef enum logic {
        REQ_EOI = 1'b0,
        REQ_DIR = 1'b1
    } req_kind_e;

    // Clear the sub-priority bits below the binary point.
    function automatic logic [7:0] prio_preempt(input logic [7:0] prio, input logic [3:0] sh);
        logic [7:0] keep;
        keep = 8'hFF << sh;
        return prio & keep;
    endfunction

endpackage

// File: rtl/eoi_lr_store.sv
module eoi_lr_store #(
    parameter int NLR   = 4,
    parameter int VID_W = 16,
    parameter int PID_W = 10,
    localparam int IDX_W = (NLR > 1) ? $clog2(NLR) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [VID_W-1:0]             wr_vid,
    input  logic [PID_W-1:0]             wr_pid,
    input  logic [7:0]                   wr_prio,
    input  logic                         wr_grp,
    input  logic                         wr_act,
    input  logic                         wr_hw,
    input  logic                         clr_en,
    input  logic [IDX_W-1:0]             clr_idx,
    output logic [NLR-1:0][VID_W-1:0]    vid,
    output logic [NLR-1:0][PID_W-1:0]    pid,
    output logic [NLR-1:0][7:0]          prio,
    output logic [NLR-1:0]               grp,
    output logic [NLR-1:0]               act,
    output logic [NLR-1:0]               hw
);

    logic [NLR-1:0][VID_W-1:0] vid_d, vid_q;
    logic [NLR-1:0][PID_W-1:0] pid_d, pid_q;
    logic [NLR-1:0][7:0]       prio_d, prio_q;
    logic [NLR-1:0]            grp_d, grp_q, act_d, act_q, hw_d, hw_q;

    always_comb begin
        vid_d  = vid_q;
        pid_d  = pid_q;
        prio_d = prio_q;
        grp_d  = grp_q;
        act_d  = act_q;
        hw_d   = hw_q;
        if (clr_en) begin
            act_d[clr_idx] = 1'b0;
        end
        // A write from the acknowledge path wins over a same-cycle clear.
        if (wr_en) begin
            vid_d[wr_idx]  = wr_vid;
            pid_d[wr_idx]  = wr_pid;
            prio_d[wr_idx] = wr_prio;
            grp_d[wr_idx]  = wr_grp;
            act_d[wr_idx]  = wr_act;
            hw_d[wr_idx]   = wr_hw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vid_q  <= '0;
            pid_q  <= '0;
            prio_q <= '0;
            grp_q  <= '0;
            act_q  <= '0;
            hw_q   <= '0;
        end else begin
            vid_q  <= vid_d;
            pid_q  <= pid_d;
            prio_q <= prio_d;
            grp_q  <= grp_d;
            act_q  <= act_d;
            hw_q   <= hw_d;
        end
    end

    assign vid  = vid_q;
    assign pid  = pid_q;
    assign prio = prio_q;
    assign grp  = grp_q;
    assign act  = act_q;
    assign hw   = hw_q;

endmodule

// File: rtl/eoi_match_find.sv
module eoi_match_find #(
    parameter int NLR   = 4,
    parameter int VID_W = 16,
    localparam int IDX_W = (NLR > 1) ? $clog2(NLR) : 1,
    localparam int USE_W = $clog2(NLR + 1)
) (
    input  logic [NLR-1:0][VID_W-1:0] vid,
    input  logic [NLR-1:0]            act,
    input  logic [USE_W-1:0]          used,
    input  logic [VID_W-1:0]          id,
    output logic                      hit,
    output logic [IDX_W-1:0]          hit_idx
);

    logic [NLR-1:0] cand;

    for (genvar i = 0; i < NLR; i++) begin : g_cmp
        assign cand[i] = act[i] && (vid[i] == id) && (USE_W'(i) < used);
    end

    // Lowest index wins: walk downward so the last assignment is the lowest.
    always_comb begin
        hit_idx = '0;
        for (int i = NLR - 1; i >= 0; i--) begin
            if (cand[i]) begin
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign hit = |cand;

endmodule

// File: rtl/eoi_deact_unit.sv
module eoi_deact_unit #(
    parameter int NLR      = 4,
    parameter int VID_W    = 16,
    parameter int PID_W    = 10,
    parameter int CNT_W    = 5,
    parameter int LPI_BASE = 8192,
    localparam int IDX_W = (NLR > 1) ? $clog2(NLR) : 1,
    localparam int USE_W = $clog2(NLR + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lr_wr_en,
    input  logic [IDX_W-1:0] lr_wr_idx,
    input  logic [VID_W-1:0] lr_wr_vid,
    input  logic [PID_W-1:0] lr_wr_pid,
    input  logic [7:0]       lr_wr_prio,
    input  logic             lr_wr_grp,
    input  logic             lr_wr_act,
    input  logic             lr_wr_hw,
    input  logic [USE_W-1:0] lr_used,
    input  logic             eoi_mode,
    input  logic [2:0]       bpr_g0,
    input  logic [2:0]       bpr_g1,
    input  logic             req_valid,
    input  logic             req_kind,
    input  logic [VID_W-1:0] req_id,
    input  logic             req_grp,
    output logic             drop_req,
    input  logic [7:0]       drop_prio,
    output logic             pdeact_valid,
    output logic [PID_W-1:0] pdeact_id,
    output logic [CNT_W-1:0] eoi_count,
    input  logic [IDX_W-1:0] lr_rd_idx,
    output logic [VID_W-1:0] lr_rd_vid,
    output logic             lr_rd_act
);
    import eoi_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pv;
        logic [PID_W-1:0] pid;
    } out_t;

    out_t out_d, out_q;

    logic [NLR-1:0][VID_W-1:0] e_vid;
    logic [NLR-1:0][PID_W-1:0] e_pid;
    logic [NLR-1:0][7:0]       e_prio;
    logic [NLR-1:0]            e_grp, e_act, e_hw;
    logic                      hit;
    logic [IDX_W-1:0]          hit_idx;
    logic                      clr_en;

    eoi_lr_store #(.NLR(NLR), .VID_W(VID_W), .PID_W(PID_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (lr_wr_en),
        .wr_idx  (lr_wr_idx),
        .wr_vid  (lr_wr_vid),
        .wr_pid  (lr_wr_pid),
        .wr_prio (lr_wr_prio),
        .wr_grp  (lr_wr_grp),
        .wr_act  (lr_wr_act),
        .wr_hw   (lr_wr_hw),
        .clr_en  (clr_en),
        .clr_idx (hit_idx),
        .vid     (e_vid),
        .pid     (e_pid),
        .prio    (e_prio),
        .grp     (e_grp),
        .act     (e_act),
        .hw      (e_hw)
    );

    eoi_match_find #(.NLR(NLR), .VID_W(VID_W)) u_find (
        .vid     (e_vid),
        .act     (e_act),
        .used    (lr_used),
        .id      (req_id),
        .hit     (hit),
        .hit_idx (hit_idx)
    );

    logic       is_eoi, is_dir, is_lpi, want, level_ok;
    logic [3:0] shift;

    always_comb begin
        is_eoi = req_valid && (req_kind_e'(req_kind) == REQ_EOI);
        is_dir = req_valid && (req_kind_e'(req_kind) == REQ_DIR);
        is_lpi = req_id >= VID_W'(LPI_BASE);
        want   = !is_lpi && ((is_eoi && !eoi_mode) || (is_dir && eoi_mode));
        shift  = req_grp ? {1'b0, bpr_g1} : ({1'b0, bpr_g0} + 4'd1);
        level_ok = is_dir ||
                   ((e_grp[hit_idx] == req_grp) &&
                    (prio_preempt(e_prio[hit_idx], shift) == drop_prio));
        clr_en = want && hit && level_ok;

        out_d     = out_q;
        out_d.pv  = 1'b0;
        out_d.pid = '0;
        if (want && !hit) begin
            out_d.cnt = out_q.cnt + 1'b1;
        end
        if (clr_en && e_hw[hit_idx]) begin
            out_d.pv  = 1'b1;
            out_d.pid = e_pid[hit_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign drop_req     = is_eoi;
    assign pdeact_valid = out_q.pv;
    assign pdeact_id    = out_q.pid;
    assign eoi_count    = out_q.cnt;
    assign lr_rd_vid    = e_vid[lr_rd_idx];
    assign lr_rd_act    = e_act[lr_rd_idx];

endmodule

// File: rtl/eoi_deact_checker.sv
module eoi_deact_checker #(
    parameter int VID_W    = 16,
    parameter int CNT_W    = 5,
    parameter int LPI_BASE = 8192
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_kind,
    input logic [VID_W-1:0] req_id,
    input logic             eoi_mode,
    input logic             pdeact_valid,
    input logic [CNT_W-1:0] eoi_count
);

    logic past_ok;
    logic lpi_req, eoi_split, dir_comb;

    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign lpi_req   = req_valid && (req_id >= VID_W'(LPI_BASE));
    assign eoi_split = req_valid && !req_kind && eoi_mode;
    assign dir_comb  = req_valid && req_kind && !eoi_mode;

    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && eoi_count != $past(eoi_count)) |-> eoi_count == CNT_W'($past(eoi_count) + 1'b1));

    p_pulse_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pdeact_valid |-> (past_ok && $past(req_valid) && !$past(lpi_req)));

    p_pulse_no_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && pdeact_valid) |-> eoi_count == $past(eoi_count));

    p_lpi_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(lpi_req)) |-> (!pdeact_valid && eoi_count == $past(eoi_count)));

    p_split_eoi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(eoi_split)) |-> (!pdeact_valid && eoi_count == $past(eoi_count)));

    p_comb_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(dir_comb)) |-> (!pdeact_valid && eoi_count == $past(eoi_count)));

endmodule

bind eoi_deact_unit eoi_deact_checker #(
    .VID_W(VID_W), .CNT_W(CNT_W), .LPI_BASE(LPI_BASE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .req_id       (req_id),
    .eoi_mode     (eoi_mode),
    .pdeact_valid (pdeact_valid),
    .eoi_count    (eoi_count)
);

// File: tb/tb_eoi_deact_unit.sv
`timescale 1ns/100ps
module tb_eoi_deact_unit;

    localparam int NLR = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lr_wr_en;
    logic [1:0]  lr_wr_idx;
    logic [15:0] lr_wr_vid;
    logic [9:0]  lr_wr_pid;
    logic [7:0]  lr_wr_prio;
    logic        lr_wr_grp, lr_wr_act, lr_wr_hw;
    logic [2:0]  lr_used;
    logic        eoi_mode;
    logic [2:0]  bpr_g0, bpr_g1;
    logic        req_valid, req_kind, req_grp;
    logic [15:0] req_id;
    logic        drop_req;
    logic [7:0]  drop_prio;
    logic        pdeact_valid;
    logic [9:0]  pdeact_id;
    logic [4:0]  eoi_count;
    logic [1:0]  lr_rd_idx;
    logic [15:0] lr_rd_vid;
    logic        lr_rd_act;

    eoi_deact_unit dut (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Reference model state
    int m_vid[NLR], m_pid[NLR], m_prio[NLR], m_grp[NLR], m_act[NLR], m_hw[NLR];
    int m_cnt = 0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int pre_lvl(input int p, input int g);
        int sh;
        sh = g ? int'(bpr_g1) : int'(bpr_g0) + 1;
        return ((p >> sh) << sh) & 255;
    endfunction

    task automatic wr_ent(input int idx, input int vid, input int pid, input int prio,
                          input int grp, input int act, input int hw);
        lr_wr_en = 1; lr_wr_idx = 2'(idx); lr_wr_vid = 16'(vid); lr_wr_pid = 10'(pid);
        lr_wr_prio = 8'(prio); lr_wr_grp = grp[0]; lr_wr_act = act[0]; lr_wr_hw = hw[0];
        m_vid[idx] = vid; m_pid[idx] = pid; m_prio[idx] = prio;
        m_grp[idx] = grp; m_act[idx] = act; m_hw[idx] = hw;
        @(posedge clk); #1;
        lr_wr_en = 0;
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < NLR; i++) begin
            lr_rd_idx = 2'(i);
            #1;
            chk(tag, int'(lr_rd_act), m_act[i]);
            if (m_act[i] != 0) chk(tag, int'(lr_rd_vid), m_vid[i]);
        end
    endtask

    task automatic do_req(input string tag, input int kind, input int id, input int grp, input int dp);
        int hit, exp_pv, exp_pid, want, ok;
        req_valid = 1; req_kind = kind[0]; req_id = 16'(id); req_grp = grp[0]; drop_prio = 8'(dp);
        #1;
        chk({tag, "/R1 drop"}, int'(drop_req), (kind == 0) ? 1 : 0);
        want = (id < 8192) && ((kind == 0 && eoi_mode == 0) || (kind == 1 && eoi_mode == 1));
        hit = -1;
        for (int i = 0; i < int'(lr_used); i++)
            if (hit < 0 && m_act[i] != 0 && m_vid[i] == id) hit = i;
        exp_pv = 0; exp_pid = 0;
        if (want != 0) begin
            if (hit < 0) m_cnt = (m_cnt + 1) % 32;
            else begin
                ok = (kind == 1) || (m_grp[hit] == grp && pre_lvl(m_prio[hit], grp) == dp);
                if (ok != 0) begin
                    m_act[hit] = 0;
                    if (m_hw[hit] != 0) begin exp_pv = 1; exp_pid = m_pid[hit]; end
                end
            end
        end
        @(posedge clk); #1;
        req_valid = 0;
        chk({tag, " pulse"}, int'(pdeact_valid), exp_pv);
        if (exp_pv != 0) chk({tag, " pid"}, int'(pdeact_id), exp_pid);
        chk({tag, " count"}, int'(eoi_count), m_cnt);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NLR; i++) begin
            m_vid[i] = 0; m_pid[i] = 0; m_prio[i] = 0; m_grp[i] = 0; m_act[i] = 0; m_hw[i] = 0;
        end
        rst_n = 0; lr_wr_en = 0; lr_wr_idx = 0; lr_wr_vid = 0; lr_wr_pid = 0; lr_wr_prio = 0;
        lr_wr_grp = 0; lr_wr_act = 0; lr_wr_hw = 0; lr_used = 3; eoi_mode = 0;
        bpr_g0 = 3'd2; bpr_g1 = 3'd3; req_valid = 0; req_kind = 0; req_id = 0; req_grp = 0;
        drop_prio = 8'hFF; lr_rd_idx = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R10 reset state
        chk("R10 count", int'(eoi_count), 0);
        chk("R10 pulse", int'(pdeact_valid), 0);
        check_all("R10 entries");

        // R11 entry loading
        wr_ent(0, 40, 300, 'h40, 1, 1, 1);
        wr_ent(1, 41, 12,  'h85, 0, 1, 0);
        wr_ent(2, 40, 20,  'h20, 1, 1, 0);
        wr_ent(3, 50, 7,   'h10, 1, 1, 1);
        check_all("R11 entries");

        // R5/R8: duplicate ID, lowest index first, hardware pulse
        do_req("R5 R8 first hit", 0, 40, 1, 'h40);
        check_all("R8 cleared");
        do_req("R5 second hit", 0, 40, 1, 'h20);
        check_all("R5 entries");
        // R5/R6: ID only beyond used count -> miss
        do_req("R5 R6 beyond used", 0, 50, 1, 'h10);
        // R7: group mismatch, then level mismatch
        do_req("R7 group", 0, 41, 1, 'h80);
        do_req("R7 level", 0, 41, 0, 'h85);
        check_all("R7 untouched");
        // R9: group 0 mask of bpr_g0+1 bits
        do_req("R9 g0", 0, 41, 0, 'h80);
        check_all("R9 cleared");
        // R2 LPI EOI
        do_req("R2 lpi eoi", 0, 8192, 1, 'hFF);
        // R4 deactivate in combined mode
        lr_used = 4;
        do_req("R4 dir mode0", 1, 50, 0, 'hFF);
        check_all("R4 untouched");
        // R3 split mode EOI
        eoi_mode = 1;
        do_req("R3 eoi mode1", 0, 50, 1, 'h10);
        check_all("R3 untouched");
        do_req("R8 dir hw", 1, 50, 0, 'hFF);
        do_req("R6 dir miss", 1, 50, 0, 'hFF);
        do_req("R2 lpi dir", 1, 9000, 0, 'hFF);
        check_all("R2 entries");
        // R6 wrap
        for (int k = 0; k < 30; k++) do_req("R6 wrap", 1, 99, 0, 'hFF);
        chk("R6 wrapped", int'(eoi_count), 0);
        // R9 group 1 with zero binary point
        eoi_mode = 0; bpr_g1 = 3'd0;
        wr_ent(2, 60, 55, 'h23, 1, 1, 1);
        do_req("R9 g1 mismatch", 0, 60, 1, 'h20);
        do_req("R9 g1 match", 0, 60, 1, 'h23);
        check_all("R9 g1 entries");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule